// File: doc/BRIEF.md
# Hashed Queue Lock Manager

This block grants and releases record-level locks kept in a lock table in shared memory. A request stream delivers lock and unlock operations, each naming a record identifier and a nonzero requester number. The block folds the identifier into a bucket index and fetches that bucket's word from the table at a base address set by the host. It then changes the word only through compare-and-swap operations. A second agent can update the same table at any time, so a failed swap makes the block fetch the word again and decide afresh.

Each bucket is one 64-bit word made of four 16-bit slots. Slot 0 sits in bits 15:0 and slot i in bits 16i+15:16i. A value of zero marks an empty slot. Slot 0 is the owner of every record that hashes to the bucket. The other slots hold waiters in arrival order. A waiter's number goes into a small wait list inside the block. When the block is otherwise idle it polls the buckets of those waiters and sends a grant once a waiter has reached slot 0.

The controller is a state machine with these states. IDLE accepts a request or starts a poll. READ fetches the bucket. PLAN decides the new word and the result code. SWAP issues the compare-and-swap. It goes to REPLY on success and back to READ on failure. REPLY holds the response until it is taken. PREAD fetches a waiter's bucket. PCHECK either grants the waiter (to REPLY) or moves on (to IDLE). When a waiter is pending and a request is also offered, IDLE alternates between polling and accepting.

Top module: `lockq_mgr`

## Requirements
- R1: The bucket index is the XOR of the record identifier cut into BKT_W-bit chunks from bit 0 upward, the last chunk zero-padded. Every table access uses address base_addr + 8*index, and the response carries that index on rsp_bkt.
- R2: A lock (req_op=0) on a bucket whose slot 0 is empty writes the requester into slot 0 and answers code 0 (grant).
- R3: A lock on a bucket whose slot 0 is taken writes the requester into the lowest empty slot and answers code 1 (queued).
- R4: A lock answers code 2 (refused) and leaves the word unchanged when all four slots are taken, or when the lock would queue and the wait list is full.
- R5: An unlock (req_op=1) by the requester in slot 0 shifts every slot down by one, clears slot 3 and answers code 3 (released).
- R6: An unlock by a requester not in slot 0, and any request with requester number 0, answer code 2 and leave the word unchanged.
- R7: The table changes only by compare-and-swap. When a swap fails because another agent changed the word, the block fetches the word again and bases its decision and its answer on the fresh value.
- R8: A requester answered with code 1 later receives one code 0 response for that bucket, found by polling, once it stands in slot 0.
- R9: A request is taken when req_valid and req_ready are both high. req_ready is low while a response or a memory access is pending. A response stays valid with stable contents until rsp_ready is high.
- R10: A memory access holds mem_req, mem_is_cas and mem_addr steady until mem_ack. The reply on mem_rdata is the word before the access, and mem_ok reports whether the swap was applied.
- R11: Right after reset, rsp_valid and mem_req are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_addr | input | ADDR_W | Byte address of bucket 0 of the lock table |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 1 | 0 lock, 1 unlock |
| req_rec | input | ID_W | Record version identifier |
| req_who | input | 16 | Requester number, nonzero |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken this cycle when valid |
| rsp_code | output | 2 | 0 grant, 1 queued, 2 refused, 3 released |
| rsp_who | output | 16 | Requester the response is for |
| rsp_bkt | output | BKT_W | Bucket index of the response |
| mem_req | output | 1 | Memory access pending |
| mem_is_cas | output | 1 | 1 compare-and-swap, 0 plain read |
| mem_addr | output | ADDR_W | Bucket word address |
| mem_cmp | output | 64 | Expected current word for the swap |
| mem_wdata | output | 64 | Word written when the swap succeeds |
| mem_ack | input | 1 | Access completed, one-cycle pulse |
| mem_ok | input | 1 | Swap applied |
| mem_rdata | input | 64 | Word as it stood before the access |

## Verification
The bench builds the block with eight buckets (BKT_W=3) and a wait list of two entries (WAIT_N=2). With the short wait list, the refusal on a full list is reached after only two queued locks. With eight buckets, three record identifiers can land in separate buckets, and one of them needs bits above the lowest chunk for the fold to give its index. The memory model can insert a foreign owner just before one swap, which forces the retry path and makes the block queue behind that owner.

// File: rtl/lockq_pkg.sv
package lockq_pkg;
    localparam int SLOT_W     = 16;
    localparam int SLOTS      = 4;
    localparam int WORD_W     = SLOT_W * SLOTS;
    localparam int SLOT_IDX_W = $clog2(SLOTS);

    typedef enum logic [1:0] {
        RSP_GRANT    = 2'd0,
        RSP_QUEUED   = 2'd1,
        RSP_REFUSED  = 2'd2,
        RSP_RELEASED = 2'd3
    } rsp_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PLAN,
        ST_SWAP,
        ST_REPLY,
        ST_PREAD,
        ST_PCHECK
    } lq_state_e;
endpackage

// File: rtl/lockq_fold.sv
module lockq_fold #(
    parameter int ID_W  = 32,
    parameter int BKT_W = 4
) (
    input  logic [ID_W-1:0]  rec,
    output logic [BKT_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int k = 0; k < ID_W; k++) begin
            idx[k % BKT_W] = idx[k % BKT_W] ^ rec[k];
        end
    end
endmodule

// File: rtl/lockq_plan.sv
module lockq_plan
    import lockq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              op_unlock,
    input  logic [SLOT_W-1:0] who,
    input  logic              wl_full,
    output logic [WORD_W-1:0] new_word,
    output logic [1:0]        code
);
    logic [SLOTS-1:0]      empty;
    logic                  have_free;
    logic [SLOT_IDX_W-1:0] free_k;
    logic [SLOT_W-1:0]     head;

    assign head = word[SLOT_W-1:0];

    for (genvar g = 0; g < SLOTS; g++) begin : g_empty
        assign empty[g] = (word[g*SLOT_W +: SLOT_W] == '0);
    end

    always_comb begin
        have_free = 1'b0;
        free_k    = '0;
        for (int i = SLOTS - 1; i >= 1; i--) begin
            if (empty[i]) begin
                have_free = 1'b1;
                free_k    = SLOT_IDX_W'(i);
            end
        end
    end

    always_comb begin
        new_word = word;
        code     = RSP_REFUSED;
        if (who != '0) begin
            if (op_unlock) begin
                if (head == who) begin
                    new_word = word >> SLOT_W;
                    code     = RSP_RELEASED;
                end
            end else if (head == '0) begin
                new_word[SLOT_W-1:0] = who;
                code                 = RSP_GRANT;
            end else if (have_free && !wl_full) begin
                new_word[free_k*SLOT_W +: SLOT_W] = who;
                code                              = RSP_QUEUED;
            end
        end
    end
endmodule

// File: rtl/lockq_waitlist.sv
module lockq_waitlist
    import lockq_pkg::*;
#(
    parameter int WAIT_N = 4,
    parameter int BKT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_who,
    input  logic [BKT_W-1:0]  push_idx,
    input  logic              pop,
    input  logic              advance,
    output logic              full,
    output logic              cur_valid,
    output logic [SLOT_W-1:0] cur_who,
    output logic [BKT_W-1:0]  cur_idx
);
    localparam int PTR_W = (WAIT_N > 1) ? $clog2(WAIT_N) : 1;

    logic [WAIT_N-1:0]       used;
    logic [SLOT_W-1:0]       who_r [WAIT_N];
    logic [BKT_W-1:0]        idx_r [WAIT_N];
    logic [PTR_W-1:0]        ptr;
    logic [PTR_W-1:0]        ptr_nx;
    logic [PTR_W-1:0]        free_p;

    assign full      = &used;
    assign cur_valid = used[ptr];
    assign cur_who   = who_r[ptr];
    assign cur_idx   = idx_r[ptr];
    assign ptr_nx    = (ptr == PTR_W'(WAIT_N - 1)) ? '0 : ptr + 1'b1;

    always_comb begin
        free_p = '0;
        for (int i = WAIT_N - 1; i >= 0; i--) begin
            if (!used[i]) free_p = PTR_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used <= '0;
            ptr  <= '0;
            for (int i = 0; i < WAIT_N; i++) begin
                who_r[i] <= '0;
                idx_r[i] <= '0;
            end
        end else begin
            if (push && !full) begin
                used[free_p]  <= 1'b1;
                who_r[free_p] <= push_who;
                idx_r[free_p] <= push_idx;
            end
            if (pop) used[ptr] <= 1'b0;
            if (pop || advance) ptr <= ptr_nx;
        end
    end
endmodule

// File: rtl/lockq_mgr.sv
module lockq_mgr
    import lockq_pkg::*;
#(
    parameter int ID_W   = 32,
    parameter int BKT_W  = 4,
    parameter int ADDR_W = 32,
    parameter int WAIT_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ID_W-1:0]   req_rec,
    input  logic [SLOT_W-1:0] req_who,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_code,
    output logic [SLOT_W-1:0] rsp_who,
    output logic [BKT_W-1:0]  rsp_bkt,
    output logic              mem_req,
    output logic              mem_is_cas,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_cmp,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_ok,
    input  logic [WORD_W-1:0] mem_rdata
);
    lq_state_e         state, state_nx;
    logic [BKT_W-1:0]  fold_idx;
    logic              op_q;
    logic [SLOT_W-1:0] who_q;
    logic [BKT_W-1:0]  idx_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] new_q;
    logic [1:0]        code_q;
    logic              poll_turn;
    logic [1:0]        rsp_code_q;
    logic [SLOT_W-1:0] rsp_who_q;
    logic [BKT_W-1:0]  rsp_bkt_q;

    logic [WORD_W-1:0] plan_new;
    logic [1:0]        plan_code;

    logic              wl_full, wl_cur_valid;
    logic [SLOT_W-1:0] wl_cur_who;
    logic [BKT_W-1:0]  wl_cur_idx;
    logic              wl_push, wl_pop, wl_advance;

    logic              poll_go;
    logic              head_match;
    logic [BKT_W-1:0]  sel_idx;

    lockq_fold #(.ID_W(ID_W), .BKT_W(BKT_W)) u_fold (
        .rec (req_rec),
        .idx (fold_idx)
    );

    lockq_plan u_plan (
        .word      (word_q),
        .op_unlock (op_q),
        .who       (who_q),
        .wl_full   (wl_full),
        .new_word  (plan_new),
        .code      (plan_code)
    );

    lockq_waitlist #(.WAIT_N(WAIT_N), .BKT_W(BKT_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wl_push),
        .push_who  (who_q),
        .push_idx  (idx_q),
        .pop       (wl_pop),
        .advance   (wl_advance),
        .full      (wl_full),
        .cur_valid (wl_cur_valid),
        .cur_who   (wl_cur_who),
        .cur_idx   (wl_cur_idx)
    );

    assign poll_go    = (state == ST_IDLE) && wl_cur_valid && (poll_turn || !req_valid);
    assign head_match = (word_q[SLOT_W-1:0] == wl_cur_who);
    assign wl_push    = (state == ST_SWAP) && mem_ack && mem_ok && (code_q == RSP_QUEUED);
    assign wl_pop     = (state == ST_PCHECK) && head_match;
    assign wl_advance = ((state == ST_IDLE) && !wl_cur_valid) ||
                        ((state == ST_PCHECK) && !head_match);

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (poll_go)        state_nx = ST_PREAD;
                else if (req_valid) state_nx = ST_READ;
            end
            ST_READ:   if (mem_ack) state_nx = ST_PLAN;
            ST_PLAN:   state_nx = (plan_code == RSP_REFUSED) ? ST_REPLY : ST_SWAP;
            ST_SWAP:   if (mem_ack) state_nx = mem_ok ? ST_REPLY : ST_READ;
            ST_REPLY:  if (rsp_ready) state_nx = ST_IDLE;
            ST_PREAD:  if (mem_ack) state_nx = ST_PCHECK;
            ST_PCHECK: state_nx = head_match ? ST_REPLY : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= 1'b0;
            who_q      <= '0;
            idx_q      <= '0;
            word_q     <= '0;
            new_q      <= '0;
            code_q     <= RSP_REFUSED;
            poll_turn  <= 1'b0;
            rsp_code_q <= RSP_REFUSED;
            rsp_who_q  <= '0;
            rsp_bkt_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (poll_go) begin
                        poll_turn <= 1'b0;
                    end else if (req_valid) begin
                        op_q      <= req_op;
                        who_q     <= req_who;
                        idx_q     <= fold_idx;
                        poll_turn <= 1'b1;
                    end
                end
                ST_READ, ST_PREAD: begin
                    if (mem_ack) word_q <= mem_rdata;
                end
                ST_PLAN: begin
                    new_q      <= plan_new;
                    code_q     <= plan_code;
                    rsp_code_q <= plan_code;
                    rsp_who_q  <= who_q;
                    rsp_bkt_q  <= idx_q;
                end
                ST_SWAP: begin
                    if (mem_ack && mem_ok) rsp_code_q <= code_q;
                end
                ST_PCHECK: begin
                    if (head_match) begin
                        rsp_code_q <= RSP_GRANT;
                        rsp_who_q  <= wl_cur_who;
                        rsp_bkt_q  <= wl_cur_idx;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sel_idx    = (state == ST_PREAD) ? wl_cur_idx : idx_q;
        req_ready  = (state == ST_IDLE) && !poll_go;
        mem_req    = (state == ST_READ) || (state == ST_SWAP) || (state == ST_PREAD);
        mem_is_cas = (state == ST_SWAP);
        mem_addr   = base_addr + ADDR_W'({sel_idx, 3'b000});
        mem_cmp    = word_q;
        mem_wdata  = new_q;
        rsp_valid  = (state == ST_REPLY);
        rsp_code   = rsp_code_q;
        rsp_who    = rsp_who_q;
        rsp_bkt    = rsp_bkt_q;
    end
endmodule

// File: rtl/lockq_mgr_chk.sv
module lockq_mgr_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] base_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [1:0]        rsp_code,
    input logic [15:0]       rsp_who,
    input logic              mem_req,
    input logic              mem_is_cas,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_cmp,
    input logic [63:0]       mem_wdata,
    input logic              mem_ack
);
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_is_cas)));

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_who)));

    assert_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_req)));

    assert_addr_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == base_addr[2:0]));

    assert_swap_changes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_is_cas) |-> (mem_wdata != mem_cmp));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rsp_valid && !mem_req));
endmodule

bind lockq_mgr lockq_mgr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_addr  (base_addr),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_code   (rsp_code),
    .rsp_who    (rsp_who),
    .mem_req    (mem_req),
    .mem_is_cas (mem_is_cas),
    .mem_addr   (mem_addr),
    .mem_cmp    (mem_cmp),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/lockq_mgr_bench.sv
module lockq_mgr_bench;
    localparam int ID_W   = 32;
    localparam int BKT_W  = 3;
    localparam int ADDR_W = 32;
    localparam int WAIT_N = 2;
    localparam logic [31:0] BASE = 32'h0000_1000;

    typedef struct packed {
        logic [1:0]       code;
        logic [15:0]      who;
        logic [BKT_W-1:0] bkt;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_op = 1'b0;
    logic [ID_W-1:0]   req_rec = '0;
    logic [15:0]       req_who = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic [1:0]        rsp_code;
    logic [15:0]       rsp_who;
    logic [BKT_W-1:0]  rsp_bkt;
    logic              mem_req, mem_is_cas;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_cmp, mem_wdata;
    logic              mem_ack = 1'b0;
    logic              mem_ok = 1'b0;
    logic [63:0]       mem_rdata = '0;

    logic [63:0]       mem [8];
    logic              inject_arm = 1'b0;
    logic              inject_done = 1'b0;
    int                swap_fails = 0;
    logic [ADDR_W-1:0] last_addr = '0;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    lockq_mgr #(.ID_W(ID_W), .BKT_W(BKT_W), .ADDR_W(ADDR_W), .WAIT_N(WAIT_N)) u_lockq_mgr (
        .clk(clk), .rst_n(rst_n), .base_addr(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_rec(req_rec), .req_who(req_who),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
        .rsp_who(rsp_who), .rsp_bkt(rsp_bkt),
        .mem_req(mem_req), .mem_is_cas(mem_is_cas), .mem_addr(mem_addr),
        .mem_cmp(mem_cmp), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_ok(mem_ok), .mem_rdata(mem_rdata)
    );

    function automatic logic [BKT_W-1:0] bkt_of(input logic [ID_W-1:0] rec);
        logic [BKT_W-1:0] r = '0;
        for (int k = 0; k < ID_W; k += BKT_W) r = r ^ BKT_W'(rec >> k);
        return r;
    endfunction

    // Shared-memory model with compare-and-swap and a one-shot foreign update
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            int i;
            logic [63:0] w;
            i = int'((mem_addr - BASE) >> 3) & 7;
            w = mem[i];
            if (mem_is_cas && inject_arm && !inject_done) begin
                w[15:0] = 16'h00AA;
                inject_done <= 1'b1;
            end
            mem_rdata <= w;
            mem_ack   <= 1'b1;
            last_addr <= mem_addr;
            if (mem_is_cas && (w == mem_cmp)) begin
                mem[i] <= mem_wdata;
                mem_ok <= 1'b1;
            end else begin
                mem[i] <= w;
                mem_ok <= 1'b0;
                if (mem_is_cas) swap_fails <= swap_fails + 1;
            end
        end else begin
            if (mem_ack) begin
                checks++;
                if (!(mem_req && mem_addr == last_addr)) begin
                    errors++;
                    $display("FAIL R10 access not held to ack: req=%0b addr=%h expected req=1 addr=%h",
                             mem_req, mem_addr, last_addr);
                end
            end
            mem_ack <= 1'b0;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected response code=%0d who=%0d bkt=%0d expected none",
                         rsp_code, rsp_who, rsp_bkt);
            end else begin
                e = exp_q.pop_front();
                if (rsp_code != e.code || rsp_who != e.who || rsp_bkt != e.bkt) begin
                    errors++;
                    $display("FAIL R1/R2-R6 response code=%0d who=%0d bkt=%0d expected code=%0d who=%0d bkt=%0d",
                             rsp_code, rsp_who, rsp_bkt, e.code, e.who, e.bkt);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL R9 watchdog cycles=%0d expected below %0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic expect_rsp(input logic [1:0] code, input logic [15:0] who, input logic [ID_W-1:0] rec);
        exp_t e;
        e.code = code; e.who = who; e.bkt = bkt_of(rec);
        exp_q.push_back(e);
    endtask

    task automatic issue(input logic op, input logic [ID_W-1:0] rec, input logic [15:0] who);
        @(negedge clk);
        req_op = op; req_rec = rec; req_who = who; req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int n = 0; n < 3000 && exp_q.size() != 0; n++) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s responses pending=%0d expected 0", tag, exp_q.size());
            exp_q.delete();
        end
        repeat (30) @(negedge clk);
    endtask

    task automatic check_word(input int i, input logic [63:0] exp, input string tag);
        checks++;
        if (mem[i] != exp) begin
            errors++;
            $display("FAIL %s bucket %0d word=%h expected %h", tag, i, mem[i], exp);
        end
    endtask

    localparam logic [31:0] REC_A = 32'h8000_0009;
    localparam logic [31:0] REC_C = 32'h0000_0005;
    localparam logic [31:0] REC_D = 32'h0000_0038;

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        checks++;
        if (rsp_valid !== 1'b0 || mem_req !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 rsp_valid=%0b mem_req=%0b req_ready=%0b expected 0 0 1",
                     rsp_valid, mem_req, req_ready);
        end
        // R1 fold reaches bits above the lowest chunk
        checks++;
        if (bkt_of(REC_A) != 3'd2) begin
            errors++;
            $display("FAIL R1 bench fold=%0d expected 2", bkt_of(REC_A));
        end

        // R2 grant on empty bucket
        expect_rsp(2'd0, 16'd1, REC_A); issue(1'b0, REC_A, 16'd1); drain("R2");
        check_word(2, 64'h0000_0000_0000_0001, "R2");
        // R3 queue behind owner, twice
        expect_rsp(2'd1, 16'd2, REC_A); issue(1'b0, REC_A, 16'd2); drain("R3");
        check_word(2, 64'h0000_0000_0002_0001, "R3");
        expect_rsp(2'd1, 16'd3, REC_A); issue(1'b0, REC_A, 16'd3); drain("R3");
        check_word(2, 64'h0000_0003_0002_0001, "R3");
        // R4 wait list full
        expect_rsp(2'd2, 16'd4, REC_A); issue(1'b0, REC_A, 16'd4); drain("R4");
        check_word(2, 64'h0000_0003_0002_0001, "R4");
        // R6 unlock by non-owner
        expect_rsp(2'd2, 16'd3, REC_A); issue(1'b1, REC_A, 16'd3); drain("R6");
        check_word(2, 64'h0000_0003_0002_0001, "R6");
        // R5 release shifts, R8 next waiter granted by polling
        expect_rsp(2'd3, 16'd1, REC_A); expect_rsp(2'd0, 16'd2, REC_A);
        issue(1'b1, REC_A, 16'd1); drain("R5/R8");
        check_word(2, 64'h0000_0000_0003_0002, "R5");
        // R7 foreign owner slips in before the swap
        inject_arm = 1'b1;
        expect_rsp(2'd1, 16'd5, REC_C); issue(1'b0, REC_C, 16'd5); drain("R7");
        check_word(5, 64'h0000_0000_0005_00AA, "R7");
        checks++;
        if (swap_fails != 1) begin
            errors++;
            $display("FAIL R7 failed swaps=%0d expected 1", swap_fails);
        end
        // R8 second promotion
        expect_rsp(2'd3, 16'd2, REC_A); expect_rsp(2'd0, 16'd3, REC_A);
        issue(1'b1, REC_A, 16'd2); drain("R8");
        check_word(2, 64'h0000_0000_0000_0003, "R5");
        // R4 bucket with all slots taken
        mem[7] = 64'h0014_0013_0012_0011;
        expect_rsp(2'd2, 16'd6, REC_D); issue(1'b0, REC_D, 16'd6); drain("R4");
        check_word(7, 64'h0014_0013_0012_0011, "R4");
        // R6 requester number zero
        expect_rsp(2'd2, 16'd0, REC_A); issue(1'b0, REC_A, 16'd0); drain("R6");
        check_word(2, 64'h0000_0000_0000_0003, "R6");
        // R9 response held under backpressure
        rsp_ready = 1'b0;
        expect_rsp(2'd3, 16'd3, REC_A); issue(1'b1, REC_A, 16'd3);
        for (int n = 0; n < 200 && !rsp_valid; n++) @(negedge clk);
        repeat (4) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_code !== 2'd3) begin
            errors++;
            $display("FAIL R9 held rsp_valid=%0b code=%0d expected 1 3", rsp_valid, rsp_code);
        end
        rsp_ready = 1'b1;
        drain("R9");
        check_word(2, 64'h0000_0000_0000_0000, "R5");
        // R2 relock after the queue emptied
        expect_rsp(2'd0, 16'd7, REC_A); issue(1'b0, REC_A, 16'd7); drain("R2");
        check_word(2, 64'h0000_0000_0000_0007, "R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule